// File: doc/BRIEF.md
# Flash Controller Power-Mode Sequencer

This block keeps the operating mode of a flash controller that sits on an asynchronous host bus: Reset, Normal or Deep Power-Down. It watches the bus strobes (chip enable, write enable, output enable), the address and the write data, plus an active-low reset pin and a power-down request pin. It decides whether a bus write may update the controller's registers, what a bus read returns, and whether the data bus is driven at all.

A mode change from software takes two writes: a mode code to a command address, then its bitwise complement to a confirmation address. Anything else in between cancels the request. A power-down request takes effect once chip enable goes high. Power-down ends after an unbroken run of twelve reads from the boot-block address, and the block then returns to the mode it left. Holding the reset pin low forces power-down, and releasing the pin leaves the block in Reset. The register contents survive power-down.

The bus is sampled on the controller clock. Each clock cycle in which a strobe pair is sampled active counts as one access.

Top module: `fpm_mode_seq`

## Requirements
- R1: After the system reset the mode output is Reset (code 2'b00; Normal is 2'b01 and Deep Power-Down is 2'b10), and the data-bus output enable is low.
- R2: A write is a sampled cycle with chip enable low and write enable low. A read is a sampled cycle with chip enable low and output enable low. Write enable or output enable low while chip enable is high has no effect.
- R3: A write of data D to the command address 0x1000 with D[1:0]=01, followed by a write of ~D (all 8 bits) to the confirmation address 0x1001, sets the mode to Normal after the clock edge that samples the confirmation. Reads between the two writes are allowed.
- R4: The pending request is discarded if the confirmation data is not the exact complement, or if any write to another address comes between the two writes. The mode then stays as it was.
- R5: In Reset mode, writes to the scratch registers (addresses 0x0000 to 0x0003) are ignored. Every read returns 0x00 with the output enable high.
- R6: In Normal mode, writes to the scratch registers store the data and reads return it. A read of 0x1000 returns the current mode code in bits [1:0] with the other bits zero. Reads of other addresses return 0x00.
- R7: While the reset pin is sampled low, the mode is Deep Power-Down. On the first cycle it is sampled high again, the mode becomes Reset.
- R8: A confirmed command with code 2'b10 arms power-down. The block enters Deep Power-Down at the first clock edge that samples chip enable high.
- R9: In Deep Power-Down, reads leave the output enable low and writes change no register.
- R10: Deep Power-Down ends after twelve consecutive reads of 0x1FFF. A read of any other address resets the count. On exit the mode returns to the mode held before entry.
- R11: Scratch register contents are the same after Deep Power-Down as before it, whether entry came from software, the power-down pin or the reset pin.
- R12: A rising edge on the power-down pin, sampled in Reset or Normal mode, enters Deep Power-Down. A later exit restores that mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | DATA_W | Write data |
| pin_rst_n | input | 1 | Reset pin, active low, forces power-down |
| pd_pin | input | 1 | Power-down request, rising-edge active |
| mode_o | output | 2 | Current mode code |
| rd_data_o | output | DATA_W | Read data |
| rd_oe_o | output | 1 | Data-bus output enable |

## Verification
The embedded assertions check, on every cycle, these properties: the data bus stays undriven during power-down, reads in Reset return zero, a held reset pin forces power-down and its release lands in Reset, registers never change outside Normal, the read-run counter stays within its limit, and Normal is reached from Reset only right after a confirmation write. Only the bench scenarios can show the following: the full command-and-complement handshake and the ways it is discarded, the exact count of twelve reads, the effect of a stray read, the restored mode after exit, and that register values survive each kind of power-down.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
   typedef enum logic [1:0] {
      MODE_RESET  = 2'b00,
      MODE_NORMAL = 2'b01,
      MODE_DPD    = 2'b10
   } pm_mode_e;

   function automatic logic code_is_valid(input logic [1:0] code);
      return code != 2'b11;
   endfunction
endpackage

// File: rtl/fpm_bus_decode.sv
module fpm_bus_decode #(
   parameter int ADDR_W    = 13,
   parameter logic [ADDR_W-1:0] CMD_ADDR  = 13'h1000,
   parameter logic [ADDR_W-1:0] CFM_ADDR  = 13'h1001,
   parameter logic [ADDR_W-1:0] BOOT_ADDR = 13'h1FFF
) (
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              wr_stb,
   output logic              rd_stb,
   output logic              hit_cmd,
   output logic              hit_cfm,
   output logic              hit_boot
);
   // R2: strobes qualify only with chip enable
   assign wr_stb   = !ce_n && !we_n;
   assign rd_stb   = !ce_n && !oe_n;
   assign hit_cmd  = addr == CMD_ADDR;
   assign hit_cfm  = addr == CFM_ADDR;
   assign hit_boot = addr == BOOT_ADDR;
endmodule

// File: rtl/fpm_confirm.sv
module fpm_confirm #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              wr_stb,
   input  logic              hit_cmd,
   input  logic              hit_cfm,
   input  logic [DATA_W-1:0] wdata,
   output logic              req_valid,
   output logic [1:0]        req_code
);
   import fpm_pkg::*;

   logic              pend_q;
   logic [DATA_W-1:0] pend_data_q;
   logic              match;

   assign match     = (wdata == ~pend_data_q) && code_is_valid(pend_data_q[1:0]);
   assign req_valid = enable && wr_stb && hit_cfm && pend_q && match;
   assign req_code  = pend_data_q[1:0];

   // R4: any write other than a fresh command discards the pending one
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_data_q <= '0;
      end else if (!enable) begin
         pend_q <= 1'b0;
      end else if (wr_stb) begin
         if (hit_cmd) begin
            pend_q      <= 1'b1;
            pend_data_q <= wdata;
         end else begin
            pend_q <= 1'b0;
         end
      end
   end

   assert_req_needs_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> pend_q && hit_cfm);
endmodule

// File: rtl/fpm_exit_cnt.sv
module fpm_exit_cnt #(
   parameter int EXIT_READS = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic rd_hit,
   input  logic rd_miss,
   output logic done
);
   localparam int CW = $clog2(EXIT_READS + 1);
   localparam logic [CW-1:0] LAST = CW'(EXIT_READS - 1);

   logic [CW-1:0] cnt_q;

   assign done = en && rd_hit && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!en || rd_miss)   cnt_q <= '0;   // R10: stray read restarts run
      else if (done)             cnt_q <= '0;
      else if (rd_hit)           cnt_q <= cnt_q + 1'b1;
   end

   assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
   assert_cnt_clear_on_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_miss |=> cnt_q == '0);
endmodule

// File: rtl/fpm_regfile.sv
module fpm_regfile #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 13,
   parameter int NUM_REGS = 4,
   parameter logic [ADDR_W-1:0] REG_BASE = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wdata,
   output logic                       hit,
   output logic [DATA_W-1:0]          rd_val,
   output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
   localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   logic [ADDR_W-1:0] offs;
   logic [DATA_W-1:0] regs_q [NUM_REGS];

   assign offs = addr - REG_BASE;
   assign hit  = (addr >= REG_BASE) && (offs < ADDR_W'(NUM_REGS));

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                         regs_q[i] <= '0;
         else if (wr_en && hit && offs == ADDR_W'(i))        regs_q[i] <= wdata;
      end
      assign regs_flat[i*DATA_W +: DATA_W] = regs_q[i];
   end

   assign rd_val = hit ? regs_q[offs[IW-1:0]] : '0;
endmodule

// File: rtl/fpm_mode_seq.sv
module fpm_mode_seq #(
   parameter int ADDR_W     = 13,
   parameter int DATA_W     = 8,
   parameter int NUM_REGS   = 4,
   parameter int EXIT_READS = 12,
   parameter logic [ADDR_W-1:0] REG_BASE  = 13'h0000,
   parameter logic [ADDR_W-1:0] CMD_ADDR  = 13'h1000,
   parameter logic [ADDR_W-1:0] CFM_ADDR  = 13'h1001,
   parameter logic [ADDR_W-1:0] BOOT_ADDR = 13'h1FFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_ce_n,
   input  logic              bus_we_n,
   input  logic              bus_oe_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              pin_rst_n,
   input  logic              pd_pin,
   output logic [1:0]        mode_o,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_oe_o
);
   import fpm_pkg::*;

   initial begin
      assert (DATA_W >= 2) else $error("DATA_W must hold a mode code");
      assert (EXIT_READS >= 1) else $error("EXIT_READS must be positive");
      assert (NUM_REGS >= 1 && NUM_REGS <= 256) else $error("NUM_REGS out of range");
      assert (CMD_ADDR != CFM_ADDR) else $error("command and confirm addresses collide");
   end

   pm_mode_e mode_q, ret_q;
   logic     from_pin_q, armed_q, pd_q;
   logic     wr_stb, rd_stb, hit_cmd, hit_cfm, hit_boot;
   logic     req_valid, exit_done, reg_hit, pd_rise;
   logic [1:0]                 req_code;
   logic [DATA_W-1:0]          reg_val;
   logic [NUM_REGS*DATA_W-1:0] regs_flat;

   fpm_bus_decode #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .CFM_ADDR(CFM_ADDR),
                    .BOOT_ADDR(BOOT_ADDR)) u_dec (
      .ce_n(bus_ce_n), .we_n(bus_we_n), .oe_n(bus_oe_n), .addr(bus_addr),
      .wr_stb(wr_stb), .rd_stb(rd_stb), .hit_cmd(hit_cmd), .hit_cfm(hit_cfm),
      .hit_boot(hit_boot));

   fpm_confirm #(.DATA_W(DATA_W)) u_cfm (
      .clk(clk), .rst_n(rst_n), .enable(mode_q != MODE_DPD),
      .wr_stb(wr_stb), .hit_cmd(hit_cmd), .hit_cfm(hit_cfm), .wdata(bus_wdata),
      .req_valid(req_valid), .req_code(req_code));

   fpm_exit_cnt #(.EXIT_READS(EXIT_READS)) u_exit (
      .clk(clk), .rst_n(rst_n),
      .en(mode_q == MODE_DPD && !from_pin_q && pin_rst_n),
      .rd_hit(rd_stb && hit_boot), .rd_miss(rd_stb && !hit_boot),
      .done(exit_done));

   fpm_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
                 .REG_BASE(REG_BASE)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_stb && mode_q == MODE_NORMAL),
      .addr(bus_addr), .wdata(bus_wdata), .hit(reg_hit), .rd_val(reg_val),
      .regs_flat(regs_flat));

   assign pd_rise = pd_pin && !pd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= MODE_RESET;
         ret_q      <= MODE_RESET;
         from_pin_q <= 1'b0;
         armed_q    <= 1'b0;
         pd_q       <= 1'b0;
      end else begin
         pd_q <= pd_pin;
         if (!pin_rst_n) begin                      // R7
            mode_q     <= MODE_DPD;
            ret_q      <= MODE_RESET;
            from_pin_q <= 1'b1;
            armed_q    <= 1'b0;
         end else if (from_pin_q) begin
            mode_q     <= MODE_RESET;
            from_pin_q <= 1'b0;
         end else if (mode_q == MODE_DPD) begin
            if (exit_done) mode_q <= ret_q;         // R10
         end else if ((armed_q && bus_ce_n) || pd_rise) begin   // R8, R12
            mode_q  <= MODE_DPD;
            ret_q   <= mode_q;
            armed_q <= 1'b0;
         end else if (req_valid) begin              // R3
            case (req_code)
               2'b01:   begin mode_q <= MODE_NORMAL; armed_q <= 1'b0; end
               2'b10:   armed_q <= 1'b1;
               default: begin mode_q <= MODE_RESET; armed_q <= 1'b0; end
            endcase
         end
      end
   end

   always_comb begin
      rd_data_o = '0;
      if (rd_stb && mode_q == MODE_NORMAL) begin
         if (reg_hit)      rd_data_o = reg_val;
         else if (hit_cmd) rd_data_o = DATA_W'(mode_q);
      end
   end
   assign rd_oe_o = rd_stb && (mode_q != MODE_DPD);
   assign mode_o  = mode_q;

   assert_dpd_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q == MODE_DPD |-> !rd_oe_o);
   assert_reset_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_RESET && rd_oe_o) |-> rd_data_o == '0);
   assert_pin_forces_dpd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_rst_n |=> mode_q == MODE_DPD);
   assert_pin_release_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_rst_n && from_pin_q) |=> mode_q == MODE_RESET);
   assert_regs_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q != MODE_NORMAL |=> $stable(regs_flat));
   assert_normal_needs_confirm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_NORMAL && $past(mode_q) == MODE_RESET) |->
         $past(wr_stb && hit_cfm));
endmodule

// File: tb/fpm_mode_seq_tb.sv
module fpm_mode_seq_tb;
   logic        clk = 0, rst_n = 0;
   logic        ce_n = 1, we_n = 1, oe_n = 1, pin_rst_n = 1, pd_pin = 0;
   logic [12:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [1:0]  mode;
   logic [7:0]  rdata;
   logic        rd_oe;
   int checks = 0, failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   fpm_mode_seq u_dut (
      .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n),
      .bus_oe_n(oe_n), .bus_addr(addr), .bus_wdata(wdata),
      .pin_rst_n(pin_rst_n), .pd_pin(pd_pin),
      .mode_o(mode), .rd_data_o(rdata), .rd_oe_o(rd_oe));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [12:0] a, input logic [7:0] d);
      @(negedge clk);
      ce_n = 0; we_n = 0; addr = a; wdata = d;
      @(negedge clk);
      ce_n = 1; we_n = 1;
   endtask

   task automatic bus_rd(input logic [12:0] a, output logic [7:0] d, output logic oe);
      @(negedge clk);
      ce_n = 0; oe_n = 0; addr = a;
      #1; d = rdata; oe = rd_oe;
      @(negedge clk);
      ce_n = 1; oe_n = 1;
   endtask

   task automatic enter_normal();
      bus_wr(13'h1000, 8'h01);
      bus_wr(13'h1001, 8'hFE);
   endtask

   task automatic boot_reads(input int n);
      logic [7:0] d; logic oe;
      for (int i = 0; i < n; i++) bus_rd(13'h1FFF, d, oe);
   endtask

   task automatic t_reset_state();
      chk("R1 mode after reset", mode, 2'b00);
      chk("R1 oe after reset", rd_oe, 1'b0);
   endtask

   task automatic t_reset_mode();
      logic [7:0] d; logic oe;
      bus_wr(13'h0000, 8'hA5);
      bus_rd(13'h0000, d, oe);
      chk("R5 reset read data", d, 8'h00);
      chk("R5 reset read oe", oe, 1'b1);
      // R2: write enable without chip enable does nothing
      @(negedge clk); we_n = 0; addr = 13'h1000; wdata = 8'h01;
      @(negedge clk); addr = 13'h1001; wdata = 8'hFE;
      @(negedge clk); we_n = 1;
      chk("R2 no chip enable no change", mode, 2'b00);
   endtask

   task automatic t_enter_normal();
      logic [7:0] d; logic oe;
      logic [7:0] rd_tmp; logic oe_tmp;
      bus_wr(13'h1000, 8'h01);
      bus_rd(13'h0002, rd_tmp, oe_tmp);     // read between the pair is allowed
      bus_wr(13'h1001, 8'hFE);
      chk("R3 mode normal", mode, 2'b01);
      bus_rd(13'h0000, d, oe);
      chk("R5 reset write was ignored", d, 8'h00);
      bus_rd(13'h1000, d, oe);
      chk("R6 command read returns mode", d, 8'h01);
   endtask

   task automatic t_discard();
      logic [7:0] d; logic oe;
      bus_wr(13'h1000, 8'h00);
      bus_wr(13'h1001, 8'h00);
      chk("R4 mismatch keeps normal", mode, 2'b01);
      bus_wr(13'h1000, 8'h00);
      bus_wr(13'h0001, 8'h3C);
      bus_wr(13'h1001, 8'hFF);
      chk("R4 intervening write keeps normal", mode, 2'b01);
      bus_rd(13'h0001, d, oe);
      chk("R6 intervening write stored", d, 8'h3C);
   endtask

   task automatic t_regs();
      logic [7:0] d; logic oe;
      for (int i = 0; i < 4; i++) bus_wr(13'(i), 8'(8'h11 * (i + 1)));
      for (int i = 0; i < 4; i++) begin
         bus_rd(13'(i), d, oe);
         chk("R6 reg readback", d, 8'(8'h11 * (i + 1)));
      end
      bus_rd(13'h0800, d, oe);
      chk("R6 unmapped reads zero", d, 8'h00);
   endtask

   task automatic t_sw_dpd_exit();
      logic [7:0] d; logic oe;
      bus_wr(13'h1000, 8'h02);
      bus_wr(13'h1001, 8'hFD);
      @(negedge clk);
      chk("R8 armed then dpd on ce high", mode, 2'b10);
      bus_rd(13'h0000, d, oe);
      chk("R9 no drive in dpd", oe, 1'b0);
      bus_wr(13'h0000, 8'hEE);
      boot_reads(5);
      bus_rd(13'h0003, d, oe);              // stray read restarts the run
      boot_reads(11);
      chk("R10 eleven reads not enough", mode, 2'b10);
      boot_reads(1);
      chk("R10 exit to prior normal", mode, 2'b01);
      bus_rd(13'h0000, d, oe);
      chk("R9 dpd write ignored", d, 8'h11);
      bus_rd(13'h0003, d, oe);
      chk("R11 reg kept across dpd", d, 8'h44);
   endtask

   task automatic t_pd_pin();
      @(negedge clk); pd_pin = 1;
      @(negedge clk);
      chk("R12 pd pin enters dpd", mode, 2'b10);
      pd_pin = 0;
      boot_reads(12);
      chk("R12 exit restores normal", mode, 2'b01);
   endtask

   task automatic t_pin_reset();
      logic [7:0] d; logic oe;
      @(negedge clk); pin_rst_n = 0;
      repeat (3) @(negedge clk);
      chk("R7 held pin gives dpd", mode, 2'b10);
      pin_rst_n = 1;
      @(negedge clk);
      chk("R7 release gives reset", mode, 2'b00);
      bus_rd(13'h0002, d, oe);
      chk("R5 reset read zero after pin", d, 8'h00);
      enter_normal();
      bus_rd(13'h0002, d, oe);
      chk("R11 reg kept across pin reset", d, 8'h33);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset_state();
      t_reset_mode();
      t_enter_normal();
      t_discard();
      t_regs();
      t_sw_dpd_exit();
      t_pd_pin();
      t_pin_reset();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule